// File: doc/BRIEF.md
# Automatic Transmit/Receive GPIO Bank

This block drives a bank of general-purpose pins on behalf of a radio. Each pin is either owned by software, which sets its level through a manual output register, or handed to the radio state. In that case the level comes from one of four pattern registers, picked by whether the receive path, the transmit path, both or neither are active. A direction register decides which pins are driven at all. Typical use is switching an external amplifier or antenna relay in step with transmit bursts, while other pins in the same bank stay under direct software control.

Software changes the configuration through a single write port. Each write carries an attribute select, a data word and a bit mask, and only the masked bits change, so several agents can share the bank without read-modify-write. A combinational read port returns any configuration register, or the pin inputs after a two-flop synchronizer.

Top module: `atr_gpio_bank`

## Requirements
- R1: While rst_ni is low, every configuration register reads zero and pin_out_o and pin_oe_o are zero, so every pin is a manual, undriven input.
- R2: A write updates only the bits of the selected register whose wr_mask_i bit is 1. All other bits keep their previous value.
- R3: The attribute select codes are 0 source select, 1 direction, 2 manual level, 3 idle pattern, 4 receive-only pattern, 5 transmit-only pattern and 6 full-duplex pattern. Reading a code returns the register written with that code.
- R4: A driven pin whose source bit is 0 outputs its manual-level bit. The manual bits of pins with source bit 1 have no effect on the pins.
- R5: A driven pin whose source bit is 1 outputs its bit of the pattern chosen by {tx_active_i, rx_active_i}: 00 idle, 01 receive-only, 10 transmit-only, 11 full duplex.
- R6: pin_oe_o equals the direction register, where 1 means output, one cycle after that register changes.
- R7: pin_out_o and pin_oe_o are registered. A change of rx_active_i or tx_active_i appears on the pins at the first rising clock edge after the change.
- R8: A pin set only in the transmit-only pattern is high only while transmitting without receiving, and low when idle, receive-only or full duplex.
- R9: Read code 7 returns pin_in_i through two flops: a new input level is visible after the second rising edge. A write with code 7 changes no register and no pin.
- R10: A pin whose direction bit is 0 has pin_out_o low, whatever its source and manual bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_attr_i | input | 3 | Attribute select for writes |
| wr_data_i | input | W | Write data |
| wr_mask_i | input | W | Per-bit write enable |
| rd_attr_i | input | 3 | Attribute select for readback |
| rd_data_o | output | W | Readback data |
| rx_active_i | input | 1 | Receive path active |
| tx_active_i | input | 1 | Transmit path active |
| pin_in_i | input | W | Pin input levels |
| pin_out_o | output | W | Pin drive levels |
| pin_oe_o | output | W | Pin output enables |

## Verification
The hardest situation to reach is a bank where automatic pins, manual pins and input-only pins coexist while the radio state moves through all four codes, including direct jumps between receive-only and full duplex. The bench configures such a mixed bank with masked writes, then walks a table of state transitions. For each step it checks the previous value just before the clock edge and the new value just after it. Later it narrows the source mask so that a pin falls back to manual control while staying an input, which exercises the input rule and the mask together.

// File: rtl/atr_gpio_pkg.sv
package atr_gpio_pkg;
  typedef enum logic [2:0] {
    ATTR_SRC  = 3'd0,
    ATTR_DIR  = 3'd1,
    ATTR_MAN  = 3'd2,
    ATTR_IDLE = 3'd3,
    ATTR_RXO  = 3'd4,
    ATTR_TXO  = 3'd5,
    ATTR_FDX  = 3'd6,
    ATTR_PINS = 3'd7
  } attr_e;

  localparam int unsigned NUM_REGS   = 7;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned PAT_BASE   = 3;
endpackage

// File: rtl/atr_gpio_regs.sv
module atr_gpio_regs
  import atr_gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            wr_en_i,
  input  logic [2:0]                      wr_attr_i,
  input  logic [W-1:0]                    wr_data_i,
  input  logic [W-1:0]                    wr_mask_i,
  output logic [NUM_REGS-1:0][W-1:0]      regs_o
);
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [W-1:0] q;
    logic         hit;
    assign hit = wr_en_i && (wr_attr_i == 3'(r));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (hit) q <= (q & ~wr_mask_i) | (wr_data_i & wr_mask_i);
    end
    assign regs_o[r] = q;
  end
endmodule

// File: rtl/atr_gpio_mux.sv
module atr_gpio_mux
  import atr_gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0]                    src_i,
  input  logic [W-1:0]                    dir_i,
  input  logic [W-1:0]                    man_i,
  input  logic [NUM_STATES-1:0][W-1:0]    pat_i,
  input  logic [1:0]                      state_i,
  output logic [W-1:0]                    out_d_o,
  output logic [W-1:0]                    oe_d_o
);
  logic [W-1:0] pat_sel;
  assign pat_sel = pat_i[state_i];

  for (genvar i = 0; i < W; i++) begin : g_pin
    // input pins are held low
    assign out_d_o[i] = dir_i[i] & (src_i[i] ? pat_sel[i] : man_i[i]);
    assign oe_d_o[i]  = dir_i[i];
  end
endmodule

// File: rtl/atr_gpio_sync.sv
module atr_gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[s] <= '0;
      else         chain_q[s] <= (s == 0) ? d_i : chain_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/atr_gpio_bank.sv
module atr_gpio_bank
  import atr_gpio_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [2:0]   wr_attr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic [W-1:0] wr_mask_i,
  input  logic [2:0]   rd_attr_i,
  output logic [W-1:0] rd_data_o,
  input  logic         rx_active_i,
  input  logic         tx_active_i,
  input  logic [W-1:0] pin_in_i,
  output logic [W-1:0] pin_out_o,
  output logic [W-1:0] pin_oe_o
);
  logic [NUM_REGS-1:0][W-1:0]   regs_w;
  logic [W-1:0]                 src_w, dir_w, man_w;
  logic [NUM_STATES-1:0][W-1:0] pat_w;
  logic [W-1:0]                 out_d, oe_d, out_q, oe_q, pins_sync;
  logic [1:0]                   radio_st;

  atr_gpio_regs #(.W(W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_attr_i (wr_attr_i),
    .wr_data_i (wr_data_i),
    .wr_mask_i (wr_mask_i),
    .regs_o    (regs_w)
  );

  assign src_w = regs_w[ATTR_SRC];
  assign dir_w = regs_w[ATTR_DIR];
  assign man_w = regs_w[ATTR_MAN];
  for (genvar s = 0; s < NUM_STATES; s++) begin : g_pat
    assign pat_w[s] = regs_w[PAT_BASE+s];
  end

  assign radio_st = {tx_active_i, rx_active_i};

  atr_gpio_mux #(.W(W)) u_mux (
    .src_i   (src_w),
    .dir_i   (dir_w),
    .man_i   (man_w),
    .pat_i   (pat_w),
    .state_i (radio_st),
    .out_d_o (out_d),
    .oe_d_o  (oe_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      oe_q  <= '0;
    end else begin
      out_q <= out_d;
      oe_q  <= oe_d;
    end
  end

  assign pin_out_o = out_q;
  assign pin_oe_o  = oe_q;

  atr_gpio_sync #(.W(W), .STAGES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_in_i),
    .q_o    (pins_sync)
  );

  always_comb begin
    if (rd_attr_i == ATTR_PINS) rd_data_o = pins_sync;
    else                        rd_data_o = regs_w[rd_attr_i];
  end
endmodule

// File: rtl/atr_gpio_chk.sv
module atr_gpio_chk #(
  parameter int unsigned W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_attr_i,
  input logic [W-1:0]     wr_mask_i,
  input logic             rx_active_i,
  input logic             tx_active_i,
  input logic [W-1:0]     src_i,
  input logic [W-1:0]     dir_i,
  input logic [W-1:0]     man_i,
  input logic [3:0][W-1:0] pat_i,
  input logic [W-1:0]     pin_out_o,
  input logic [W-1:0]     pin_oe_o
);
  logic [W-1:0] exp_pat;
  always_comb begin
    if (tx_active_i && rx_active_i) exp_pat = pat_i[3];
    else if (tx_active_i)           exp_pat = pat_i[2];
    else if (rx_active_i)           exp_pat = pat_i[1];
    else                            exp_pat = pat_i[0];
  end

  p_src_mask_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_attr_i == 3'd0) |=> (((src_i ^ $past(src_i)) & ~$past(wr_mask_i)) == '0));

  p_dir_mask_keep_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_attr_i == 3'd1) |=> (((dir_i ^ $past(dir_i)) & ~$past(wr_mask_i)) == '0));

  p_manual_pins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pin_out_o ^ $past(man_i)) & $past(~src_i & dir_i)) == '0));

  p_auto_pins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (((pin_out_o ^ $past(exp_pat)) & $past(src_i & dir_i)) == '0));

  p_oe_tracks_dir_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pin_oe_o == $past(dir_i)));

  p_input_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((pin_out_o & ~pin_oe_o) == '0));
endmodule

bind atr_gpio_bank atr_gpio_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_attr_i   (wr_attr_i),
  .wr_mask_i   (wr_mask_i),
  .rx_active_i (rx_active_i),
  .tx_active_i (tx_active_i),
  .src_i       (src_w),
  .dir_i       (dir_w),
  .man_i       (man_w),
  .pat_i       (pat_w),
  .pin_out_o   (pin_out_o),
  .pin_oe_o    (pin_oe_o)
);

// File: tb/tb_atr_gpio_bank.sv
`timescale 1ns/1ps
module tb_atr_gpio_bank;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni;
  logic         wr_en;
  logic [2:0]   wr_attr, rd_attr;
  logic [W-1:0] wr_data, wr_mask, rd_data, pin_in, pin_out, pin_oe;
  logic         rx_act, tx_act;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  atr_gpio_bank #(.W(W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_attr_i(wr_attr),
    .wr_data_i(wr_data), .wr_mask_i(wr_mask), .rd_attr_i(rd_attr),
    .rd_data_o(rd_data), .rx_active_i(rx_act), .tx_active_i(tx_act),
    .pin_in_i(pin_in), .pin_out_o(pin_out), .pin_oe_o(pin_oe)
  );

  // {tx, rx, expected pin_out}
  localparam logic [9:0] VEC [8] = '{
    {2'b01, 8'h0C}, {2'b11, 8'h9C}, {2'b10, 8'h4C}, {2'b00, 8'h1C},
    {2'b10, 8'h4C}, {2'b01, 8'h0C}, {2'b11, 8'h9C}, {2'b00, 8'h1C}
  };
  localparam logic [W-1:0] CFG [7] = '{8'hF0, 8'hDF, 8'h0C, 8'h15, 8'h2A, 8'h4F, 8'hB0};

  task automatic check(string req, logic [W-1:0] got, logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [W-1:0] d, logic [W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_attr = a; wr_data = d; wr_mask = m;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; wr_mask = '0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_ni = 1'b1; wr_en = 1'b0; wr_attr = '0; wr_data = '0; wr_mask = '0;
    rd_attr = '0; rx_act = 1'b0; tx_act = 1'b0; pin_in = '0;
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 pin_out", pin_out, '0);
    check("R1 pin_oe", pin_oe, '0);
    for (int a = 0; a < 7; a++) begin
      rd_attr = 3'(a); #1;
      check("R1 readback", rd_data, '0);
    end
    rst_ni = 1'b1;

    // write in two masked halves to exercise R2 as well
    for (int a = 0; a < 7; a++) begin
      wr(3'(a), CFG[a], 8'h0F);
      wr(3'(a), CFG[a], 8'hF0);
    end
    @(posedge clk); @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd_attr = 3'(a); #1;
      check("R3 readback by code", rd_data, CFG[a]);
    end
    check("R6 oe equals direction", pin_oe, 8'hDF);
    check("R5 idle pattern", pin_out, 8'h1C);

    begin
      logic [W-1:0] prev;
      prev = 8'h1C;
      for (int v = 0; v < 8; v++) begin
        @(negedge clk);
        {tx_act, rx_act} = VEC[v][9:8];
        #1 check("R7 no change before edge", pin_out, prev);
        @(posedge clk); @(negedge clk);
        check("R5 state pattern", pin_out, VEC[v][7:0]);
        check("R8 tx-only pin", {7'b0, pin_out[6]}, {7'b0, VEC[v][9:8] == 2'b10});
        prev = VEC[v][7:0];
      end
    end

    // R4: manual bits drive manual pins, ignored on automatic pins
    wr(3'd2, 8'h03, 8'h0F);
    @(posedge clk); @(negedge clk);
    check("R4 manual level", pin_out, 8'h13);
    wr(3'd2, 8'hF0, 8'hF0);
    @(posedge clk); @(negedge clk);
    check("R4 manual ignored on auto pins", pin_out, 8'h13);

    // R2: clear source bits 4,5 only
    wr(3'd0, 8'h00, 8'h30);
    rd_attr = 3'd0; #1;
    check("R2 masked update", rd_data, 8'hC0);
    @(posedge clk); @(negedge clk);
    check("R10 input pin stays low", {7'b0, pin_out[5]}, 8'h00);
    check("R4 pin4 now manual", {7'b0, pin_out[4]}, 8'h01);

    // R9: two-flop input path
    rd_attr = 3'd7;
    @(negedge clk); pin_in = 8'hA5;
    @(posedge clk); @(negedge clk);
    check("R9 one edge old value", rd_data, 8'h00);
    @(posedge clk); @(negedge clk);
    check("R9 two edges new value", rd_data, 8'hA5);
    wr(3'd7, 8'hFF, 8'hFF);
    @(posedge clk); @(negedge clk);
    check("R9 write to code 7 ignored pins", pin_out, 8'h13);
    check("R9 write to code 7 ignored oe", pin_oe, 8'hDF);
    for (int a = 1; a < 7; a++) begin
      rd_attr = 3'(a); #1;
      check("R9 registers untouched", rd_data, (a == 2) ? 8'hF3 : CFG[a]);
    end

    // R1: reset mid-run
    @(negedge clk); rst_ni = 1'b0; #1;
    check("R1 async reset pins", pin_out, '0);
    check("R1 async reset oe", pin_oe, '0);
    rd_attr = 3'd5; #1;
    check("R1 async reset register", rd_data, '0);
    finish_run();
  end
endmodule